// File: doc/BRIEF.md
# Memory Watchpoint and Access-Error Interrupt Unit

This block observes the access streams of three memory ports: an on-chip RAM port (port 0), an instruction tightly-coupled memory port (port 1) and a data tightly-coupled memory port (port 2). Each port has its own watch register. The register holds a doubleword-granular address and a direction selector. Any access on that port whose direction and address bits 18 down to 3 agree with the register is a watch hit. Each port also has an error input that the memory decoder pulses when the port touches an address outside its allocated region.

Watch hits and access errors are recorded in a sticky status register. A status-enable mask decides which events may set a flag. A second signal-enable mask decides which set flags reach the single registered interrupt output. Software clears a flag by writing 1 to its bit. All state resets to zero, so after reset no event is recorded and no interrupt is raised.

Top module: `memwatch_unit`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: A watch register holds the compare address in bits [16:1]. An access hits when its address bits [18:3] equal those bits. Address bits [2:0] and bits 19 and up do not take part in the compare.
- R3: Watch register bit 0 selects the direction that can hit: 0 selects reads (`acc_write`=0) and 1 selects writes (`acc_write`=1). An access in the other direction never hits.
- R4: A watch hit on port p, with status-enable bit 3+p set, sets status bit 3+p at the clock edge that samples the access.
- R5: A pulse on `unalloc_err[p]`, with status-enable bit p set, sets status bit p at the clock edge that samples it.
- R6: An event whose status-enable bit is 0 leaves the status register unchanged.
- R7: Writing the status register (offset 0) clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R8: When a flag is set by an enabled event and cleared by a write in the same cycle, the flag ends up set.
- R9: `irq` is a register loaded with the OR over all bits of (status AND signal-enable). It rises one clock edge after the flag is set and falls one clock edge after the flag or its enable is cleared.
- R10: An access on one port never sets a flag belonging to another port, even when its address matches that other port's watch register.
- R11: Register offsets are: 0 status, 1 status-enable (6 bits), 2 signal-enable (6 bits), 3/4/5 watch registers for ports 0/1/2 (17 bits). Registers 1 to 5 read back what was written, masked to their width. Offsets 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 3 | Per-port access strobe, one cycle per access |
| acc_write | input | 3 | Per-port direction, 1 = write, 0 = read |
| acc_addr | input | 96 | Per-port byte address, port p in bits [32p+31:32p] |
| unalloc_err | input | 3 | Per-port unallocated-address error pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Combined registered interrupt |

## Verification
A table of accesses drives the comparator's edges. It covers low address bits and high address bits that must be ignored, the all-ones and top-bit compare fields, near misses by one doubleword, and direction mismatches. A design that compared the full address, or compared it at byte granularity, would miss the hits in that table. Directed tests go after the same-cycle set-and-clear race, where a design that let the clear win would lose an event. They also check partial write-1-clear, where an inverted mask would wipe live flags. Port isolation is checked, which catches a swapped or shared match route. The interrupt latency is checked on both edges, so a combinational or two-stage `irq` shows up as an early or late edge.

// File: rtl/memwatch_pkg.sv
package memwatch_pkg;

    // port numbering
    localparam int NUM_PORTS = 3;
    localparam int PORT_RAM  = 0;
    localparam int PORT_ITCM = 1;
    localparam int PORT_DTCM = 2;

    // access address and watch field geometry
    localparam int ADDR_W   = 32;
    localparam int WADDR_LO = 3;
    localparam int WADDR_HI = 18;
    localparam int WFIELD_W = WADDR_HI - WADDR_LO + 1;
    localparam int WATCH_W  = WFIELD_W + 1;

    // status layout: bits [NUM_PORTS-1:0] access errors, next NUM_PORTS watch hits
    localparam int STAT_W    = 2 * NUM_PORTS;
    localparam int ERR_BASE  = 0;
    localparam int HIT_BASE  = NUM_PORTS;

    // register interface
    localparam int DATA_W     = 32;
    localparam int REG_AW     = 3;
    localparam int RA_STATUS  = 0;
    localparam int RA_STAT_EN = 1;
    localparam int RA_SIG_EN  = 2;
    localparam int RA_WATCH0  = 3;

    // watch register: compare field above, direction selector in bit 0
    typedef struct packed {
        logic [WFIELD_W-1:0] field;
        logic                on_write;
    } watch_cfg_t;

endpackage

// File: rtl/memwatch_cmp.sv
module memwatch_cmp
    import memwatch_pkg::*;
(
    input  watch_cfg_t          cfg,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic                hit
);

    logic dir_ok;
    logic addr_ok;
    logic unused_addr_bits;

    always_comb begin
        dir_ok  = (acc_write == cfg.on_write);
        addr_ok = (acc_addr[WADDR_HI:WADDR_LO] == cfg.field);
        hit     = acc_valid && dir_ok && addr_ok;
    end

    assign unused_addr_bits = ^{acc_addr[ADDR_W-1:WADDR_HI+1], acc_addr[WADDR_LO-1:0]};

endmodule

// File: rtl/memwatch_status.sv
module memwatch_status
    import memwatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt,
    input  logic [STAT_W-1:0] en,
    input  logic [STAT_W-1:0] clr,
    output logic [STAT_W-1:0] status
);

    typedef struct packed {
        logic [STAT_W-1:0] flags;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic [STAT_W-1:0] set_vec;

    always_comb begin
        set_vec     = evt & en;
        st_d        = st_q;
        // clear first, then set, so a same-cycle set survives
        st_d.flags  = (st_q.flags & ~clr) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.flags;

    // enabled events are present in the flags one edge later, whatever the clear says
    p_enabled_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & en) != '0) |=> ((status & $past(evt & en)) == $past(evt & en)));

    // a clear without a same-cycle set empties the flag
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~(evt & en)) != '0) |=> ((status & $past(clr & ~(evt & en))) == '0));

    // no flag rises without an enabled event behind it
    p_no_masked_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(evt & en)) == '0));

    // flags are sticky unless cleared
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~clr) != '0) |=> ((status & $past(status & ~clr)) == $past(status & ~clr)));

endmodule

// File: rtl/memwatch_regs.sv
module memwatch_regs
    import memwatch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic [STAT_W-1:0]     status,
    output logic [STAT_W-1:0]     stat_en,
    output logic [STAT_W-1:0]     sig_en,
    output watch_cfg_t            watch [NUM_PORTS],
    output logic [STAT_W-1:0]     clr,
    output logic [DATA_W-1:0]     reg_rdata
);

    typedef struct packed {
        logic [STAT_W-1:0]                  stat_en;
        logic [STAT_W-1:0]                  sig_en;
        watch_cfg_t [NUM_PORTS-1:0]         watch;
    } cfg_state_t;

    cfg_state_t r_d, r_q;
    int         wr_idx;
    int         rd_idx;
    logic       unused_wdata_bits;

    always_comb begin
        r_d    = r_q;
        clr    = '0;
        wr_idx = int'(reg_addr);
        if (reg_wr) begin
            if (wr_idx == RA_STATUS)  clr       = reg_wdata[STAT_W-1:0];
            if (wr_idx == RA_STAT_EN) r_d.stat_en = reg_wdata[STAT_W-1:0];
            if (wr_idx == RA_SIG_EN)  r_d.sig_en  = reg_wdata[STAT_W-1:0];
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (wr_idx == RA_WATCH0 + p)
                    r_d.watch[p] = watch_cfg_t'(reg_wdata[WATCH_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_idx    = int'(reg_addr);
        reg_rdata = '0;
        if (rd_idx == RA_STATUS)  reg_rdata = DATA_W'(status);
        if (rd_idx == RA_STAT_EN) reg_rdata = DATA_W'(r_q.stat_en);
        if (rd_idx == RA_SIG_EN)  reg_rdata = DATA_W'(r_q.sig_en);
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_idx == RA_WATCH0 + p) reg_rdata = DATA_W'(r_q.watch[p]);
        end
    end

    assign stat_en = r_q.stat_en;
    assign sig_en  = r_q.sig_en;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_watch_out
        assign watch[g] = r_q.watch[g];
    end

    assign unused_wdata_bits = ^reg_wdata[DATA_W-1:WATCH_W];

    // writes outside the mapped range touch nothing
    p_unmapped_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(reg_addr) >= RA_WATCH0 + NUM_PORTS) |=> $stable(r_q));

    // a register write never needs a status clear unless it targets the status offset
    p_clear_only_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |-> (reg_wr && int'(reg_addr) == RA_STATUS));

endmodule

// File: rtl/memwatch_unit.sv
module memwatch_unit
    import memwatch_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS-1:0]          acc_valid,
    input  logic [NUM_PORTS-1:0]          acc_write,
    input  logic [NUM_PORTS*ADDR_W-1:0]   acc_addr,
    input  logic [NUM_PORTS-1:0]          unalloc_err,
    input  logic                          reg_wr,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic                          irq
);

    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t       irq_d, irq_q;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] stat_en;
    logic [STAT_W-1:0] sig_en;
    logic [STAT_W-1:0] clr;
    logic [STAT_W-1:0] evt;
    logic [NUM_PORTS-1:0] hit;
    watch_cfg_t        watch [NUM_PORTS];

    memwatch_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (status),
        .stat_en   (stat_en),
        .sig_en    (sig_en),
        .watch     (watch),
        .clr       (clr),
        .reg_rdata (reg_rdata)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        memwatch_cmp i_cmp (
            .cfg       (watch[g]),
            .acc_valid (acc_valid[g]),
            .acc_write (acc_write[g]),
            .acc_addr  (acc_addr[g*ADDR_W +: ADDR_W]),
            .hit       (hit[g])
        );

        // a watch flag only rises after an access on its own port in its own direction
        p_hit_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[HIT_BASE+g]) |->
                $past(acc_valid[g] && (acc_write[g] == watch[g].on_write)));

        // the flag that records an error comes from that port's error input
        p_err_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[ERR_BASE+g]) |-> $past(unalloc_err[g] && stat_en[ERR_BASE+g]));
    end

    always_comb begin
        evt = '0;
        evt[ERR_BASE +: NUM_PORTS] = unalloc_err;
        evt[HIT_BASE +: NUM_PORTS] = hit;
    end

    memwatch_status i_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .en     (stat_en),
        .clr    (clr),
        .status (status)
    );

    always_comb begin
        irq_d     = irq_q;
        irq_d.irq = |(status & sig_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q.irq;

    // irq high only when a signalled flag was present the cycle before
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((status & sig_en) != '0));

    // a signalled flag always raises irq on the next edge
    p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & sig_en) != '0) |=> irq);

endmodule

// File: tb/test_memwatch_unit.sv
module test_memwatch_unit;

    localparam int NP = 3;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   acc_valid = '0;
    logic [NP-1:0]   acc_write = '0;
    logic [NP*AW-1:0] acc_addr = '0;
    logic [NP-1:0]   unalloc_err = '0;
    logic            reg_wr = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    memwatch_unit i_memwatch_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_addr    (acc_addr),
        .unalloc_err (unalloc_err),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq         (irq)
    );

    // entry: port[52:51] sel[50] wr[49] field[48:33] addr[32:1] expect_hit[0]
    localparam int NV = 8;
    localparam logic [52:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 16'h0012, 32'h0000_0090, 1'b1},
        {2'd0, 1'b0, 1'b0, 16'h0012, 32'h0000_0097, 1'b1},
        {2'd1, 1'b1, 1'b1, 16'h1234, 32'hFFF8_91A0, 1'b1},
        {2'd1, 1'b1, 1'b0, 16'h1234, 32'h0000_91A0, 1'b0},
        {2'd2, 1'b0, 1'b0, 16'hFFFF, 32'h0007_FFF8, 1'b1},
        {2'd2, 1'b0, 1'b0, 16'hFFFF, 32'h0007_FFF0, 1'b0},
        {2'd0, 1'b1, 1'b1, 16'h0000, 32'h0000_0004, 1'b1},
        {2'd2, 1'b1, 1'b1, 16'h8000, 32'h0004_0000, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 3'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 3'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic access(input int p, input logic w, input logic [31:0] a);
        @(negedge clk);
        acc_valid    = '0;
        acc_write    = '0;
        acc_addr     = '0;
        acc_valid[p] = 1'b1;
        acc_write[p] = w;
        acc_addr[p*AW +: AW] = a;
        @(negedge clk);
        acc_valid = '0;
        acc_write = '0;
        acc_addr  = '0;
    endtask

    task automatic err_pulse(input logic [NP-1:0] m);
        @(negedge clk);
        unalloc_err = m;
        @(negedge clk);
        unalloc_err = '0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, v);
            check("R1 register reset", v, 32'h0);
        end
        check("R1 irq reset", {31'b0, irq}, 32'h0);

        // R11 map and readback
        wr(2, 32'hFFFF_FFEA);
        rd(2, v);
        check("R11 signal-enable readback", v, 32'h2A);
        wr(3, 32'hFFFF_FFFF);
        rd(3, v);
        check("R11 watch0 readback", v, 32'h1_FFFF);
        wr(6, 32'hFFFF_FFFF);
        rd(6, v);
        check("R11 offset 6 reads zero", v, 32'h0);
        rd(1, v);
        check("R11 unmapped write left status-enable", v, 32'h0);
        rd(2, v);
        check("R11 unmapped write left signal-enable", v, 32'h2A);
        wr(2, 32'h0);
        wr(3, 32'h0);

        // table of watch compares, R2 R3 R4
        wr(1, 32'h3F);
        for (int i = 0; i < NV; i++) begin
            int          p;
            logic [31:0] exp;
            p = int'(VEC[i][52:51]);
            wr(3 + p, {15'b0, VEC[i][48:33], VEC[i][50]});
            access(p, VEC[i][49], VEC[i][32:1]);
            rd(0, v);
            exp = VEC[i][0] ? (32'h1 << (3 + p)) : 32'h0;
            check($sformatf("R2 R3 R4 vector %0d", i), v, exp);
            wr(0, 32'h3F);
            wr(3 + p, 32'h0);
        end

        // R5 error flag
        err_pulse(3'b010);
        rd(0, v);
        check("R5 error flag port1", v, 32'h02);
        wr(0, 32'h3F);

        // R6 masked events
        wr(1, 32'h0);
        wr(3, {15'b0, 16'h0040, 1'b0});
        err_pulse(3'b111);
        access(0, 1'b0, 32'h0000_0200);
        rd(0, v);
        check("R6 disabled events ignored", v, 32'h0);
        wr(1, 32'h3F);

        // R10 port isolation: port0 access at port1's watch address
        wr(3, 32'h0);
        wr(4, {15'b0, 16'h0040, 1'b0});
        access(0, 1'b0, 32'h0000_0200);
        rd(0, v);
        check("R10 other port not flagged", v, 32'h0);
        access(1, 1'b0, 32'h0000_0200);
        rd(0, v);
        check("R10 own port flagged", v, 32'h10);
        wr(0, 32'h3F);
        wr(4, 32'h0);

        // R7 partial clear
        err_pulse(3'b101);
        wr(0, 32'h0);
        rd(0, v);
        check("R7 write of zero keeps flags", v, 32'h05);
        wr(0, 32'h01);
        rd(0, v);
        check("R7 clear of one flag", v, 32'h04);

        // R8 set beats clear in the same cycle; bit0 re-set then cleared alongside
        err_pulse(3'b001);
        @(negedge clk);
        unalloc_err = 3'b100;
        reg_wr      = 1'b1;
        reg_addr    = 3'd0;
        reg_wdata   = 32'h05;
        @(negedge clk);
        unalloc_err = '0;
        reg_wr      = 1'b0;
        reg_wdata   = '0;
        rd(0, v);
        check("R8 set wins over clear", v, 32'h04);
        wr(0, 32'h3F);

        // R9 interrupt latency and masking
        wr(2, 32'h02);
        err_pulse(3'b001);
        check("R9 irq masked by signal-enable", {31'b0, irq}, 32'h0);
        @(negedge clk);
        unalloc_err = 3'b010;
        @(negedge clk);
        unalloc_err = '0;
        check("R9 irq one edge after flag", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R9 irq asserted", {31'b0, irq}, 32'h1);
        wr(0, 32'h02);
        check("R9 irq still high after clear edge", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R9 irq falls", {31'b0, irq}, 32'h0);
        rd(0, v);
        check("R9 unsignalled flag remains", v, 32'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule